// File: doc/BRIEF.md
# Packed Lane Compare and Select Unit

This block treats a 32-bit word as a row of independent lanes and produces, for every lane, the outcome of an equality or ordering test, the smaller or larger of the two operand lanes, or the clamped magnitude of the first operand lane. Lane width and signedness are not carried in the opcode. They follow from the register numbers of the operands: each group of register numbers holds one lane format, so the index of the first source register picks 8-bit or 16-bit lanes and signed or unsigned order for the whole word.

Each request carries the operation code, a two-bit mode field, both source register indices and both operand words. Requests enter over a valid/ready stream and the result leaves over a second valid/ready stream through a single output register. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result shows on `out_data` with `out_valid` high from the next edge on, and stays unchanged until a clock edge that also sees `out_ready` high. `in_ready` is high whenever the output register is empty or being drained in the same cycle, so a continuous stream moves one request per cycle.

A compare lane comes out as all ones when the test holds and as all zeros when it fails. Lane 0 sits in the least significant bits of the word.

Top module: `pcmp_unit`

## Requirements
- R1: The index on `in_a_idx` selects the lane format: 2 to 7 gives signed 8-bit lanes, 8 to 15 gives unsigned 8-bit lanes, 16 to 23 gives signed 16-bit lanes, and 24 to 29 gives unsigned 16-bit lanes. Lane i occupies bits [i*W +: W].
- R2: When `in_a_idx` is 0, 1, 30 or 31, the result word is all zeros. For every operation except absolute value, the result is also all zeros when `in_b_idx` lies in a different group from `in_a_idx`.
- R3: Operation code 0 (equal) sets a lane to all ones when the a-lane and b-lane bit patterns match, and clears it otherwise. Signedness plays no part.
- R4: Operation code 1 (less-than) is the inverse of greater-or-equal. Operation code 2 (less-or-equal) is the inverse of greater-than. Signed groups use two's-complement order and unsigned groups use magnitude order. A lane is all ones when true and all zeros when false.
- R5: Operation code 3 returns the smaller of each lane pair and code 4 returns the larger, using the order the group selects.
- R6: Operation code 5 returns the absolute value of each a-lane in a signed group. The most negative lane value gives the most positive value, so no result lane has its top bit set. In an unsigned group the a-lane passes through unchanged.
- R7: Codes 0 to 4 need mode 00 and code 5 needs mode 01. Any other mode, and the codes 6 and 7, give an all-zero result.
- R8: Results leave in the order the requests were taken, each exactly once.
- R9: A request taken on an edge makes `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_data` holds and `in_ready` is low.
- R10: While `rst_n` is low, `out_valid` is low. After reset `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 3 | Operation code |
| in_mode | input | 2 | Mode field |
| in_a_idx | input | 5 | Register index of the first operand, selects lane format |
| in_b_idx | input | 5 | Register index of the second operand |
| in_a | input | 32 | First operand word |
| in_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Packed result word |

## Verification
On one edge the output register can hand its result to the consumer and also take the next request. This is the case where a wrong ready term would drop or repeat a result. The bench causes it by sending back-to-back requests while `out_ready` toggles at random. It judges the case with an ordered queue of expected words: a result is popped only on a cycle where the output handshake completes, and a new expectation is pushed only on a cycle where the input handshake completes. A directed stall is also held for several cycles, and across it `out_data` must stay stable and `in_ready` must stay low.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
  parameter int DATA_W   = 32;
  parameter int NARROW_W = 8;
  parameter int WIDE_W   = 16;
  parameter int IDX_W    = 5;
  parameter int OP_W     = 3;
  parameter int MODE_W   = 2;

  parameter int S8_LO  = 2;
  parameter int U8_LO  = 8;
  parameter int S16_LO = 16;
  parameter int U16_LO = 24;
  parameter int U16_HI = 29;

  localparam int N_NARROW = DATA_W / NARROW_W;
  localparam int N_WIDE   = DATA_W / WIDE_W;

  typedef enum logic [OP_W-1:0] {
    OP_EQ  = 3'd0,
    OP_LT  = 3'd1,
    OP_LE  = 3'd2,
    OP_MIN = 3'd3,
    OP_MAX = 3'd4,
    OP_ABS = 3'd5
  } pcmp_op_e;

  typedef enum logic [2:0] {
    BK_NONE = 3'd0,
    BK_S8   = 3'd1,
    BK_U8   = 3'd2,
    BK_S16  = 3'd3,
    BK_U16  = 3'd4
  } pcmp_bank_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              is_cmp;
    logic              abs_signed;
    logic              wide;
  } pcmp_payload_t;

  localparam int PAYLOAD_W = $bits(pcmp_payload_t);
endpackage

// File: rtl/pcmp_bank_dec.sv
module pcmp_bank_dec
  import pcmp_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output pcmp_bank_e       bank
);
  localparam logic [IDX_W-1:0] S8_B  = IDX_W'(S8_LO);
  localparam logic [IDX_W-1:0] U8_B  = IDX_W'(U8_LO);
  localparam logic [IDX_W-1:0] S16_B = IDX_W'(S16_LO);
  localparam logic [IDX_W-1:0] U16_B = IDX_W'(U16_LO);
  localparam logic [IDX_W-1:0] END_B = IDX_W'(U16_HI);

  always_comb begin
    if (idx < S8_B || idx > END_B) bank = BK_NONE;
    else if (idx < U8_B)           bank = BK_S8;
    else if (idx < S16_B)          bank = BK_U8;
    else if (idx < U16_B)          bank = BK_S16;
    else                           bank = BK_U16;
  end
endmodule

// File: rtl/pcmp_lane.sv
module pcmp_lane
  import pcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  input  pcmp_op_e     op,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic eq, gt, ge, lt, le;
  logic [W-1:0] mag;

  always_comb begin
    eq = (a == b);
    gt = sgn ? ($signed(a) > $signed(b)) : (a > b);
    ge = gt | eq;
    // less-than is the inverse of greater-or-equal
    lt = ~ge;
    le = ~gt;
  end

  always_comb begin
    if (sgn && a[W-1]) mag = (a == MOST_NEG) ? MOST_POS : (~a + 1'b1);
    else               mag = a;
  end

  always_comb begin
    unique case (op)
      OP_EQ:   res = {W{eq}};
      OP_LT:   res = {W{lt}};
      OP_LE:   res = {W{le}};
      OP_MIN:  res = gt ? b : a;
      OP_MAX:  res = gt ? a : b;
      OP_ABS:  res = mag;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/pcmp_core.sv
module pcmp_core
  import pcmp_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  pcmp_op_e          op,
  input  logic              sgn,
  input  logic              wide,
  input  logic              legal,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] res_n, res_w;

  for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
    pcmp_lane #(.W(NARROW_W)) u_lane (
      .a   (a[i*NARROW_W +: NARROW_W]),
      .b   (b[i*NARROW_W +: NARROW_W]),
      .sgn (sgn),
      .op  (op),
      .res (res_n[i*NARROW_W +: NARROW_W])
    );
  end

  for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
    pcmp_lane #(.W(WIDE_W)) u_lane (
      .a   (a[j*WIDE_W +: WIDE_W]),
      .b   (b[j*WIDE_W +: WIDE_W]),
      .sgn (sgn),
      .op  (op),
      .res (res_w[j*WIDE_W +: WIDE_W])
    );
  end

  always_comb begin
    if (!legal)    res = '0;
    else if (wide) res = res_w;
    else           res = res_n;
  end
endmodule

// File: rtl/pcmp_out_stage.sv
module pcmp_out_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic          vld_q;
  logic [PW-1:0] dat_q;

  assign in_ready  = ~vld_q | out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vld_q <= 1'b0;
    else if (in_ready) vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     dat_q <= '0;
    else if (in_valid && in_ready)  dat_q <= in_data;
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  take_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: rtl/pcmp_unit.sv
module pcmp_unit
  import pcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [IDX_W-1:0]  in_a_idx,
  input  logic [IDX_W-1:0]  in_b_idx,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam logic [MODE_W-1:0] MODE_PLAIN = MODE_W'(0);
  localparam logic [MODE_W-1:0] MODE_SAT   = MODE_W'(1);

  pcmp_bank_e    bank_a, bank_b;
  pcmp_op_e      op;
  logic          op_known, mode_ok, bank_ok, legal, sgn, wide;
  logic [DATA_W-1:0] core_res;
  pcmp_payload_t pl_in, pl_out;

  pcmp_bank_dec u_dec_a (.idx(in_a_idx), .bank(bank_a));
  pcmp_bank_dec u_dec_b (.idx(in_b_idx), .bank(bank_b));

  always_comb begin
    op       = pcmp_op_e'(in_op);
    op_known = (in_op <= OP_W'(OP_ABS));
    mode_ok  = (op == OP_ABS) ? (in_mode == MODE_SAT) : (in_mode == MODE_PLAIN);
    bank_ok  = (bank_a != BK_NONE) && ((op == OP_ABS) || (bank_b == bank_a));
    legal    = op_known && mode_ok && bank_ok;
    sgn      = (bank_a == BK_S8) || (bank_a == BK_S16);
    wide     = (bank_a == BK_S16) || (bank_a == BK_U16);
  end

  pcmp_core u_core (
    .a     (in_a),
    .b     (in_b),
    .op    (op),
    .sgn   (sgn),
    .wide  (wide),
    .legal (legal),
    .res   (core_res)
  );

  always_comb begin
    pl_in.data       = core_res;
    pl_in.is_cmp     = (op == OP_EQ) || (op == OP_LT) || (op == OP_LE);
    pl_in.abs_signed = legal && (op == OP_ABS) && sgn;
    pl_in.wide       = wide;
  end

  pcmp_out_stage #(.PW(PAYLOAD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pl_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pl_out)
  );

  assign out_data = pl_out.data;

  function automatic logic lanes_uniform(input logic [DATA_W-1:0] d, input logic w);
    logic ok;
    ok = 1'b1;
    if (w) begin
      for (int i = 0; i < N_WIDE; i++)
        ok &= (d[i*WIDE_W +: WIDE_W] == '0) || (d[i*WIDE_W +: WIDE_W] == '1);
    end else begin
      for (int i = 0; i < N_NARROW; i++)
        ok &= (d[i*NARROW_W +: NARROW_W] == '0) || (d[i*NARROW_W +: NARROW_W] == '1);
    end
    return ok;
  endfunction

  function automatic logic no_lane_negative(input logic [DATA_W-1:0] d, input logic w);
    logic ok;
    ok = 1'b1;
    if (w) begin
      for (int i = 0; i < N_WIDE; i++) ok &= ~d[i*WIDE_W + WIDE_W - 1];
    end else begin
      for (int i = 0; i < N_NARROW; i++) ok &= ~d[i*NARROW_W + NARROW_W - 1];
    end
    return ok;
  endfunction

  // R3 R4
  cmp_lane_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && pl_out.is_cmp |-> lanes_uniform(pl_out.data, pl_out.wide));

  // R6
  abs_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && pl_out.abs_signed |-> no_lane_negative(pl_out.data, pl_out.wide));
endmodule

// File: tb/pcmp_unit_tb.sv
module pcmp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_op;
  logic [1:0]  in_mode;
  logic [4:0]  in_a_idx, in_b_idx;
  logic [31:0] in_a, in_b;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit rnd_ready = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  pcmp_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_mode(in_mode),
    .in_a_idx(in_a_idx), .in_b_idx(in_b_idx),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // group code: 0 none, 1 s8, 2 u8, 3 s16, 4 u16
  function automatic int group_of(input logic [4:0] i);
    if (i >= 2 && i <= 7)   return 1;
    if (i >= 8 && i <= 15)  return 2;
    if (i >= 16 && i <= 23) return 3;
    if (i >= 24 && i <= 29) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] model(input logic [2:0] op, input logic [1:0] md,
                                        input logic [4:0] ai, input logic [4:0] bi,
                                        input logic [31:0] a, input logic [31:0] b,
                                        output string tag);
    int ga, gb, w, n, mask, half;
    bit sg;
    logic [31:0] r;
    r = '0;
    ga = group_of(ai);
    gb = group_of(bi);
    if (op > 3'd5) begin tag = "R7"; return '0; end
    if (ga == 0 || (op != 3'd5 && gb != ga)) begin tag = "R2"; return '0; end
    if (md != ((op == 3'd5) ? 2'd1 : 2'd0)) begin tag = "R7"; return '0; end
    case (op)
      3'd0: tag = "R3";
      3'd1, 3'd2: tag = "R4";
      3'd3, 3'd4: tag = "R5";
      default: tag = "R6";
    endcase
    w    = (ga <= 2) ? 8 : 16;
    sg   = (ga == 1 || ga == 3);
    n    = 32 / w;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    for (int i = 0; i < n; i++) begin
      int x, y, v;
      x = int'(a >> (i * w)) & mask;
      y = int'(b >> (i * w)) & mask;
      if (sg && x >= half) x -= (1 << w);
      if (sg && y >= half) y -= (1 << w);
      case (op)
        3'd0: v = (x == y) ? -1 : 0;
        3'd1: v = (x < y) ? -1 : 0;
        3'd2: v = (x <= y) ? -1 : 0;
        3'd3: v = (x < y) ? x : y;
        3'd4: v = (x > y) ? x : y;
        default: v = (sg && x < 0) ? ((-x > half - 1) ? half - 1 : -x) : x;
      endcase
      r |= 32'(v & mask) << (i * w);
    end
    return r;
  endfunction

  // scoreboard: pop on output handshake, push on input handshake (R8)
  always @(negedge clk) begin
    #5;
    if (mon_en && rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected result", out_data, 32'h0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(out_data === e.d, {e.tag, " R8"}, out_data, e.d);
        end
      end
      if (in_valid && in_ready) begin
        exp_t e;
        e.d = model(in_op, in_mode, in_a_idx, in_b_idx, in_a, in_b, e.tag);
        exp_q.push_back(e);
      end
    end
  end

  always @(negedge clk) begin
    if (rnd_ready) out_ready <= ($urandom_range(0, 9) < 6);
  end

  task automatic send(input logic [2:0] op, input logic [1:0] md, input logic [4:0] ai,
                      input logic [4:0] bi, input logic [31:0] a, input logic [31:0] b);
    bit taken;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_mode = md;
    in_a_idx = ai; in_b_idx = bi; in_a = a; in_b = b;
    taken = 1'b0;
    while (!taken) begin
      #5;
      taken = in_ready;
      @(posedge clk);
      if (!taken) @(negedge clk);
    end
  endtask

  task automatic idle(input int cyc);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  function automatic logic [7:0] pick_byte();
    case ($urandom_range(0, 6))
      0: return 8'h00;
      1: return 8'h7f;
      2: return 8'h80;
      3: return 8'hff;
      4: return 8'h01;
      default: return 8'($urandom);
    endcase
  endfunction

  function automatic logic [31:0] pick_word();
    return {pick_byte(), pick_byte(), pick_byte(), pick_byte()};
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h1234_abcd));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_op = '0; in_mode = '0; in_a_idx = '0; in_b_idx = '0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    #5;
    // R10
    chk(out_valid == 1'b0, "R10 out_valid in reset", {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    #5;
    // R10
    chk(in_ready == 1'b1, "R10 in_ready after reset", {31'b0, in_ready}, 32'h1);

    // R3 equality, signed and unsigned narrow, wide
    send(3'd0, 2'd0, 5'd2, 5'd3, 32'h80_7f_01_00, 32'h80_00_01_ff);
    send(3'd0, 2'd0, 5'd9, 5'd15, 32'hdead_beef, 32'hdead_0000);
    send(3'd0, 2'd0, 5'd17, 5'd22, 32'h8000_1234, 32'h8000_1235);
    // R1 R4 signed versus unsigned order on same bits
    send(3'd1, 2'd0, 5'd4, 5'd5, 32'h80_80_01_7f, 32'h01_80_80_7f);
    send(3'd1, 2'd0, 5'd10, 5'd11, 32'h80_80_01_7f, 32'h01_80_80_7f);
    send(3'd2, 2'd0, 5'd4, 5'd5, 32'h80_80_01_7f, 32'h01_80_80_7f);
    send(3'd2, 2'd0, 5'd12, 5'd13, 32'h80_80_01_7f, 32'h01_80_80_7f);
    send(3'd1, 2'd0, 5'd16, 5'd20, 32'h8000_0001, 32'h0001_8000);
    send(3'd2, 2'd0, 5'd24, 5'd29, 32'h8000_0001, 32'h0001_0001);
    // R5 min / max
    send(3'd3, 2'd0, 5'd6, 5'd7, 32'h80_7f_ff_00, 32'h7f_80_00_ff);
    send(3'd4, 2'd0, 5'd8, 5'd14, 32'h80_7f_ff_00, 32'h7f_80_00_ff);
    send(3'd3, 2'd0, 5'd25, 5'd26, 32'hffff_0001, 32'h0001_ffff);
    send(3'd4, 2'd0, 5'd18, 5'd19, 32'hffff_8000, 32'h0001_7fff);
    // R6 absolute value with saturation
    send(3'd5, 2'd1, 5'd3, 5'd0, 32'h80_81_ff_7f, 32'h0);
    send(3'd5, 2'd1, 5'd21, 5'd31, 32'h8000_8001, 32'h0);
    send(3'd5, 2'd1, 5'd27, 5'd27, 32'h8000_ffff, 32'h0);
    send(3'd5, 2'd1, 5'd9, 5'd9, 32'h80_ff_01_00, 32'h0);
    // R2 illegal indices and group mismatch
    send(3'd0, 2'd0, 5'd0, 5'd0, 32'h0, 32'h0);
    send(3'd0, 2'd0, 5'd30, 5'd30, 32'h1, 32'h1);
    send(3'd5, 2'd1, 5'd1, 5'd2, 32'h80808080, 32'h0);
    send(3'd0, 2'd0, 5'd3, 5'd9, 32'h5, 32'h5);
    // R7 mode and opcode rules
    send(3'd5, 2'd0, 5'd3, 5'd3, 32'h80808080, 32'h0);
    send(3'd3, 2'd1, 5'd3, 5'd3, 32'h01020304, 32'h04030201);
    send(3'd0, 2'd2, 5'd3, 5'd3, 32'h0, 32'h0);
    send(3'd6, 2'd0, 5'd3, 5'd3, 32'h0, 32'h0);
    send(3'd7, 2'd1, 5'd3, 5'd3, 32'h0, 32'h0);
    idle(3);

    // R9 stall: result holds and input is blocked
    @(negedge clk);
    out_ready = 1'b0;
    send(3'd4, 2'd0, 5'd2, 5'd2, 32'h11_22_33_44, 32'h44_33_22_11);
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'd0; in_mode = 2'd0;
    in_a_idx = 5'd2; in_b_idx = 5'd2; in_a = 32'h0; in_b = 32'h0;
    #5;
    chk(out_valid == 1'b1, "R9 valid after take", {31'b0, out_valid}, 32'h1);
    chk(in_ready == 1'b0, "R9 ready low in stall", {31'b0, in_ready}, 32'h0);
    held = out_data;
    chk(held == 32'h44_33_33_44, "R5 R9 stalled value", held, 32'h44_33_33_44);
    repeat (3) begin
      @(negedge clk); #5;
      chk(out_data == held && out_valid, "R9 hold under stall", out_data, held);
      chk(in_ready == 1'b0, "R9 input blocked", {31'b0, in_ready}, 32'h0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b0;
    idle(3);

    // random stream with random back-pressure
    rnd_ready = 1'b1;
    for (int k = 0; k < 600; k++) begin
      logic [2:0] op;
      logic [1:0] md;
      logic [4:0] ai, bi;
      op = ($urandom_range(0, 19) == 0) ? 3'($urandom_range(6, 7)) : 3'($urandom_range(0, 5));
      md = (op == 3'd5) ? 2'd1 : 2'd0;
      if ($urandom_range(0, 9) == 0) md = 2'($urandom);
      ai = 5'($urandom);
      bi = ($urandom_range(0, 4) == 0) ? 5'($urandom) : ai;
      if ($urandom_range(0, 3) == 0) idle($urandom_range(0, 2));
      send(op, md, ai, bi, pick_word(), ($urandom_range(0, 4) == 0) ? 32'h0 : pick_word());
    end
    @(negedge clk);
    in_valid = 1'b0;
    rnd_ready = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (6) @(negedge clk);
    #6;
    // R8
    chk(exp_q.size() == 0, "R8 all results delivered", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule